// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block paints a 32 by 32 pixel, two-bit-per-pixel cursor over an RGB pixel stream. Each incoming pixel comes with its screen column and row. When that coordinate falls inside the cursor window, the block looks up the pixel's 2-bit code in an internal 256-byte bitmap. Depending on a mode bit, the code selects a cursor colour, leaves the pixel unchanged, or inverts it. Pixels outside the window pass through untouched. Every pixel leaves exactly one clock after it enters.

Software configures the block through a small register port. One address loads the bitmap write pointer. Another accepts one bitmap byte per write and advances the pointer. The other addresses hold the cursor's upper-left position, three colour registers and the mode bit.

Top module: `cursor_overlay`

## Requirements
- R1: Every accepted pixel appears at the output exactly one clock later. `pix_valid_o` copies `pix_valid_i` with a delay of one cycle. After reset, `pix_valid_o` and `pix_rgb_o` are 0.
- R2: A pixel whose column is outside [pos_x, pos_x+31], or whose row is outside [pos_y, pos_y+31], is output unchanged. This includes the pixel just past the right edge and the pixel just below the bottom edge.
- R3: A register write to address 0 loads the bitmap pointer from `reg_wdata_i[7:0]`. A write to address 1 stores `reg_wdata_i[7:0]` at the pointer and then adds one to the pointer, wrapping from 255 to 0.
- R4: In a bitmap byte, the pixel at window column c takes bits [2*(c mod 4)+1 : 2*(c mod 4)].
- R5: The window pixel at column c and row r, both relative to the upper-left corner, reads bitmap byte r*8 + c/4.
- R6: With the mode bit at 0, the codes act as follows: 00 gives colour 0, 01 gives colour 1, 10 passes the input pixel through, and 11 outputs the bitwise inverse of the input pixel.
- R7: With the mode bit at 1, the codes act as follows: 00 passes the input pixel through, 01 gives colour 0, 10 gives colour 1, and 11 gives colour 2.
- R8: The remaining register addresses are: 2 for the window's left column (`reg_wdata_i[10:0]`), 3 for its top row, 4, 5 and 6 for colours 0, 1 and 2 (`reg_wdata_i[23:0]`), and 7 for the mode bit (`reg_wdata_i[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 24 | Register write data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 11 | Input pixel column |
| pix_y_i | input | 11 | Input pixel row |
| pix_rgb_i | input | 24 | Input pixel colour |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Output pixel colour |

## Verification
The bench sweeps a 34 by 34 area that surrounds the window in both modes, so it tests the four edges and the cells just outside them. An off-by-one compare would tint the column or row next to the window, or would drop the last column or row of the window.

The bitmap holds a different computed value in every byte. A swapped row/column index, or a nibble taken from the wrong end of a byte, therefore yields wrong colours at specific pixels.

The pointer is loaded at 255 before two bytes are written. A pointer that saturates, or that fails to wrap, would leave byte 0 stale. A swapped code table in either mode shows up as a colour or an inversion where the requirement expects something else.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int unsigned CUR_DIM   = 32;
  localparam int unsigned CUR_BPP   = 2;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PIX_PER_B = BYTE_W / CUR_BPP;
  localparam int unsigned BM_BYTES  = CUR_DIM * CUR_DIM / PIX_PER_B;
  localparam int unsigned BM_AW     = $clog2(BM_BYTES);
  localparam int unsigned SLOT_W    = $clog2(PIX_PER_B);
  localparam int unsigned DIM_W     = $clog2(CUR_DIM);

  typedef enum logic [2:0] {
    REG_PTR  = 3'd0,
    REG_DATA = 3'd1,
    REG_POSX = 3'd2,
    REG_POSY = 3'd3,
    REG_COL0 = 3'd4,
    REG_COL1 = 3'd5,
    REG_COL2 = 3'd6,
    REG_MODE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap
  import cursor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_load_i,
  input  logic [BM_AW-1:0]  ptr_val_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BM_AW-1:0]  rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] mem_q [BM_BYTES];
  logic [BM_AW-1:0]  ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= ptr_val_i;
    else if (wr_i)       ptr_q <= ptr_q + 1'b1;  // natural wrap
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[ptr_q] <= wdata_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R3: pointer advances by one per data write
  a_r3_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ptr_load_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int unsigned COORD_W = 11
) (
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [COORD_W-1:0] pos_x_i,
  input  logic [COORD_W-1:0] pos_y_i,
  output logic               hit_o,
  output logic [BM_AW-1:0]   byte_addr_o,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [COORD_W-1:0] rel_x, rel_y;
  logic               in_x, in_y;

  assign rel_x = pix_x_i - pos_x_i;
  assign rel_y = pix_y_i - pos_y_i;
  assign in_x  = (pix_x_i >= pos_x_i) && (rel_x < COORD_W'(CUR_DIM));
  assign in_y  = (pix_y_i >= pos_y_i) && (rel_y < COORD_W'(CUR_DIM));
  assign hit_o = in_x && in_y;

  // row-major: DIM/PIX_PER_B bytes per row, column slot inside the byte
  assign byte_addr_o = {rel_y[DIM_W-1:0], rel_x[DIM_W-1:SLOT_W]};
  assign slot_o      = rel_x[SLOT_W-1:0];
endmodule

// File: rtl/cursor_decode.sv
module cursor_decode
  import cursor_pkg::*;
#(
  parameter int unsigned RGB_W = 24
) (
  input  logic               mode_i,
  input  logic               hit_i,
  input  logic [CUR_BPP-1:0] code_i,
  input  logic [RGB_W-1:0]   pix_i,
  input  logic [RGB_W-1:0]   col0_i,
  input  logic [RGB_W-1:0]   col1_i,
  input  logic [RGB_W-1:0]   col2_i,
  output logic [RGB_W-1:0]   pix_o
);
  always_comb begin
    pix_o = pix_i;
    if (hit_i) begin
      if (!mode_i) begin
        unique case (code_i)
          2'b00:   pix_o = col0_i;
          2'b01:   pix_o = col1_i;
          2'b10:   pix_o = pix_i;
          default: pix_o = ~pix_i;
        endcase
      end else begin
        unique case (code_i)
          2'b00:   pix_o = pix_i;
          2'b01:   pix_o = col0_i;
          2'b10:   pix_o = col1_i;
          default: pix_o = col2_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned RGB_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [RGB_W-1:0]   reg_wdata_i,
  input  logic               pix_valid_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [RGB_W-1:0]   pix_rgb_i,
  output logic               pix_valid_o,
  output logic [RGB_W-1:0]   pix_rgb_o
);
  logic [COORD_W-1:0] pos_x_q, pos_y_q;
  logic [RGB_W-1:0]   col_q [3];
  logic               mode_q;
  logic               hit;
  logic [BM_AW-1:0]   byte_addr;
  logic [SLOT_W-1:0]  slot;
  logic [BYTE_W-1:0]  bm_byte;
  logic [CUR_BPP-1:0] code;
  logic [RGB_W-1:0]   mixed;
  logic               live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_x_q <= '0;
      pos_y_q <= '0;
      mode_q  <= 1'b0;
      for (int i = 0; i < 3; i++) col_q[i] <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_e'(reg_addr_i))
        REG_POSX: pos_x_q  <= reg_wdata_i[COORD_W-1:0];
        REG_POSY: pos_y_q  <= reg_wdata_i[COORD_W-1:0];
        REG_COL0: col_q[0] <= reg_wdata_i;
        REG_COL1: col_q[1] <= reg_wdata_i;
        REG_COL2: col_q[2] <= reg_wdata_i;
        REG_MODE: mode_q   <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  cursor_bitmap u_bitmap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_load_i (reg_we_i && reg_addr_i == REG_PTR),
    .ptr_val_i  (reg_wdata_i[BM_AW-1:0]),
    .wr_i       (reg_we_i && reg_addr_i == REG_DATA),
    .wdata_i    (reg_wdata_i[BYTE_W-1:0]),
    .rd_addr_i  (byte_addr),
    .rd_data_o  (bm_byte)
  );

  cursor_window #(.COORD_W(COORD_W)) u_window (
    .pix_x_i     (pix_x_i),
    .pix_y_i     (pix_y_i),
    .pos_x_i     (pos_x_q),
    .pos_y_i     (pos_y_q),
    .hit_o       (hit),
    .byte_addr_o (byte_addr),
    .slot_o      (slot)
  );

  // pixel n of the byte sits at the LSB end
  assign code = CUR_BPP'(bm_byte >> (slot * CUR_BPP));

  cursor_decode #(.RGB_W(RGB_W)) u_decode (
    .mode_i (mode_q),
    .hit_i  (hit),
    .code_i (code),
    .pix_i  (pix_rgb_i),
    .col0_i (col_q[0]),
    .col1_i (col_q[1]),
    .col2_i (col_q[2]),
    .pix_o  (mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
      live_q      <= 1'b0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_rgb_o   <= mixed;
      live_q      <= 1'b1;
    end
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (pix_valid_o == $past(pix_valid_i)));

  a_r2_outside_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!hit)) |-> (pix_rgb_o == $past(pix_rgb_i)));

  a_r6_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(hit && !mode_q && code == 2'b11)) |-> (pix_rgb_o == ~$past(pix_rgb_i)));

  a_r7_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(hit && mode_q && code == 2'b00)) |-> (pix_rgb_o == $past(pix_rgb_i)));
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [10:0] pix_x = '0, pix_y = '0;
  logic [23:0] pix_rgb = '0;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] col [3];
  logic [7:0]  shadow [256];

  always #10 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .pix_valid_i(pix_valid), .pix_x_i(pix_x),
    .pix_y_i(pix_y), .pix_rgb_i(pix_rgb), .pix_valid_o(pix_valid_o),
    .pix_rgb_o(pix_rgb_o)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // drive one pixel, sample one cycle later away from the edge
  task automatic pixel(logic v, int x, int y, logic [23:0] rgb,
                       output logic ov, output logic [23:0] orgb);
    @(negedge clk);
    pix_valid = v; pix_x = 11'(x); pix_y = 11'(y); pix_rgb = rgb;
    @(posedge clk); #2;
    ov = pix_valid_o; orgb = pix_rgb_o;
  endtask

  function automatic logic [23:0] expect_pix(bit mode, int x, int y, int px, int py,
                                             logic [23:0] rgb);
    int c, r;
    logic [1:0] code;
    c = x - px; r = y - py;
    if (c < 0 || c > 31 || r < 0 || r > 31) return rgb;
    code = 2'((shadow[r * 8 + c / 4]) >> (2 * (c % 4)));
    if (!mode) case (code)
      2'd0: return col[0];
      2'd1: return col[1];
      2'd2: return rgb;
      default: return ~rgb;
    endcase
    else case (code)
      2'd0: return rgb;
      2'd1: return col[0];
      2'd2: return col[1];
      default: return col[2];
    endcase
  endfunction

  task automatic t_reset;
    check("R1 reset valid", 32'(pix_valid_o), 0);
    check("R1 reset rgb", 32'(pix_rgb_o), 0);
  endtask

  task automatic t_load;
    col[0] = 24'h12_34_56; col[1] = 24'hA0_B0_C0; col[2] = 24'h0F_F0_5A;
    wr(3'd4, col[0]); wr(3'd5, col[1]); wr(3'd6, col[2]);
    wr(3'd2, 24'd100); wr(3'd3, 24'd40);
    wr(3'd0, 24'd0);
    for (int a = 0; a < 256; a++) begin
      wr(3'd1, 24'(pat(a)));
      shadow[a] = pat(a);
    end
  endtask

  task automatic t_sweep(bit mode, string req);
    logic ov; logic [23:0] o, rgb, exp;
    wr(3'd7, 24'(mode));
    for (int y = 39; y <= 72; y++)
      for (int x = 99; x <= 132; x++) begin
        rgb = 24'((x * 7919) ^ (y * 104729));
        pixel(1'b1, x, y, rgb, ov, o);
        exp = expect_pix(mode, x, y, 100, 40, rgb);
        if (x < 100 || x > 131 || y < 40 || y > 71)
          check("R2 outside", 32'(o), 32'(exp));
        else
          check({req, " R4 R5 R8 in window"}, 32'(o), 32'(exp));
        check("R1 valid", 32'(ov), 1);
      end
  endtask

  task automatic t_wrap;
    logic ov; logic [23:0] o;
    wr(3'd7, 24'd1);
    wr(3'd0, 24'd255);
    wr(3'd1, 24'hFF); wr(3'd1, 24'h2D);
    shadow[255] = 8'hFF; shadow[0] = 8'h2D;
    // byte 0 = 2D -> codes c0=01 c1=11 c2=10 c3=00
    for (int c = 0; c < 4; c++) begin
      pixel(1'b1, 100 + c, 40, 24'h55_66_77, ov, o);
      check("R3 wrap byte0", 32'(o), 32'(expect_pix(1'b1, 100 + c, 40, 100, 40, 24'h55_66_77)));
    end
    pixel(1'b1, 131, 71, 24'h55_66_77, ov, o);
    check("R3 byte255", 32'(o), 32'(col[2]));
    pixel(1'b0, 0, 0, 24'h01_02_03, ov, o);
    check("R1 invalid", 32'(ov), 0);
    check("R2 far outside", 32'(o), 32'h01_02_03);
  endtask

  task automatic t_move;
    logic ov; logic [23:0] o;
    wr(3'd2, 24'd0); wr(3'd3, 24'd0);
    pixel(1'b1, 31, 31, 24'h00_00_11, ov, o);
    check("R8 moved window", 32'(o), 32'(expect_pix(1'b1, 31, 31, 0, 0, 24'h00_00_11)));
    pixel(1'b1, 32, 0, 24'h00_00_22, ov, o);
    check("R2 right edge", 32'(o), 32'h00_00_22);
    pixel(1'b1, 0, 32, 24'h00_00_33, ov, o);
    check("R2 bottom edge", 32'(o), 32'h00_00_33);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_load();
    t_sweep(1'b0, "R6");
    t_sweep(1'b1, "R7");
    t_wrap();
    t_move();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule